// File: doc/BRIEF.md
# Vector Issue Queue with Full-Queue Slow Wakeup

This block is the out-of-order issue stage in front of a group of vector execution pipes. Dispatched micro-ops enter at the young end of a compacting queue. Each micro-op carries a destination tag, a target pipe and two source operands. For every source the entry records the producer's tag and the producer's latency. When a producer issues, its tag is broadcast on one of the wakeup ports. The waiting source then counts down that latency and becomes ready when the count runs out. Every cycle, each pipe is granted the oldest entry that targets it and has all of its sources ready. Granted entries leave the queue, and the entries behind them slide toward the old end in order.

Wakeup timing depends on how full the queue is. If the queue is completely full in the cycle a broadcast arrives, the `SLOW_N` oldest positions form a slow region. A source in that region whose producer has a one-cycle latency wakes one cycle later than it otherwise would. Producers with longer latencies, which includes loads (they are dispatched with their load latency), give no added delay. Positions outside the slow region also give no added delay. So does any position at all while the queue has a free slot, and this is why padding a stream with no-op entries that consume no result avoids the penalty.

Dispatch is a valid/ready stream. A micro-op is taken on a clock edge where `disp_valid` and `disp_ready` are both high. `disp_ready` depends only on the queue's occupancy and drops while the queue is full. While `disp_ready` is low, the upstream stage must hold the micro-op. A request made while `disp_ready` is low has no effect. Wakeup broadcasts and issue grants are plain pins: a broadcast cannot be refused, and the execution pipes always take a grant.

Top module: `vq_sched`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is 1 and no `iss_valid` bit is set.
- R2: A micro-op is accepted when `disp_valid` and `disp_ready` are both 1. `disp_ready` is 0 exactly while the queue holds DEPTH entries. A request made while `disp_ready` is 0 never enters the queue and is never granted.
- R3: A source dispatched with its ready flag set counts as ready at once. A waiting source of latency L (1 to 7) whose tag is broadcast in cycle T is ready in cycle T+L.
- R4: If the queue is full in cycle T and the entry is among the SLOW_N oldest positions, a waiting source with L = 1 whose tag is broadcast in cycle T becomes ready in cycle T+2.
- R5: A source in the slow region whose producer has L > 1 (loads included) is ready in cycle T+L, with no extra cycle.
- R6: If the queue has at least one free slot in cycle T, no position sees the extra cycle, whatever the latency.
- R7: Each pipe p is granted, in a cycle, the oldest entry that has its pipe field equal to p and all of its sources ready. There is at most one grant per pipe, and several pipes may be granted in the same cycle. Granted entries are removed at the next edge and the remaining entries keep their relative age.
- R8: Issue and dispatch may happen in the same cycle. An entry dispatched in cycle T can be granted no earlier than T+1. A broadcast in the dispatch cycle that matches a source of the new entry wakes that source, with no slow-region delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue can take a micro-op |
| disp_dst | input | TAG_W | Destination tag of the micro-op |
| disp_pipe | input | PIPE_W | Target execution pipe |
| disp_src_tag | input | NSRC*TAG_W | Producer tag per source |
| disp_src_lat | input | NSRC*LAT_W | Producer latency per source (1 or more) |
| disp_src_rdy | input | NSRC | Source already available at dispatch |
| bc_valid | input | NBC | Wakeup broadcast valid per port |
| bc_tag | input | NBC*TAG_W | Tag of the issuing producer per port |
| iss_valid | output | NPIPE | Grant per pipe |
| iss_dst | output | NPIPE*TAG_W | Destination tag of the granted entry per pipe |

## Verification
The two functions that can fall in the same cycle are removing a granted entry and appending a new one at the young end. A third event can join them: a wakeup broadcast that targets both the compacting old entries and the arriving one. The bench provokes this directly. It dispatches a ready micro-op while an earlier one is being granted, and it dispatches a waiting micro-op in the same cycle its producer's tag is broadcast. Long random runs with heavy dispatch keep the queue close to full, so grants, appends and broadcasts overlap there constantly. Each cycle a bench model, which tracks absolute ready cycles rather than counters, judges the grants and the ready signal. Directed cases check the exact cycle in which the slow-region entries issue.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int TAG_W  = 6;
  localparam int LAT_W  = 3;
  localparam int PIPE_W = 2;
  localparam int NSRC   = 2;

  typedef struct packed {
    logic             rdy;
    logic             armed;
    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] lat;
    logic [TAG_W-1:0] tag;
  } src_t;

  typedef struct packed {
    logic              vld;
    logic [PIPE_W-1:0] pipe;
    logic [TAG_W-1:0]  dst;
    src_t [NSRC-1:0]   src;
  } ent_t;

  function automatic logic src_live(src_t s);
    return s.rdy | (s.armed & (s.cnt == '0));
  endfunction
endpackage

// File: rtl/vq_src_wake.sv
module vq_src_wake
  import vq_pkg::*;
#(
  parameter int NBC = 4
) (
  input  src_t                 cur,
  input  logic [NBC-1:0]       bc_valid,
  input  logic [NBC*TAG_W-1:0] bc_tag,
  input  logic                 slow,
  output src_t                 nxt
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int b = 0; b < NBC; b++)
      if (bc_valid[b] && bc_tag[b*TAG_W +: TAG_W] == cur.tag) hit = 1'b1;
  end

  always_comb begin
    nxt = cur;
    if (!cur.rdy && !cur.armed && hit) begin
      nxt.armed = 1'b1;
      if (cur.lat == '0) nxt.cnt = '0;
      else nxt.cnt = cur.lat - LAT_W'(1) + LAT_W'(slow && cur.lat == LAT_W'(1));
    end else if (cur.armed && cur.cnt != '0) begin
      nxt.cnt = cur.cnt - LAT_W'(1);
    end
  end
endmodule

// File: rtl/vq_pick.sv
module vq_pick
  import vq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NPIPE = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       elig,
  input  logic [DEPTH*PIPE_W-1:0] pipe_of,
  output logic [NPIPE-1:0]       gnt_vld,
  output logic [NPIPE*IDX_W-1:0] gnt_idx
);
  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic [DEPTH-1:0] gv;
    logic [IDX_W-1:0] idx;
    logic             hit;

    always_comb begin
      gv  = '0;
      idx = '0;
      hit = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (elig[i] && pipe_of[i*PIPE_W +: PIPE_W] == PIPE_W'(p)) begin
          gv    = '0;
          gv[i] = 1'b1;
          idx   = IDX_W'(i);
          hit   = 1'b1;
        end
      end
    end

    assign gnt_vld[p] = hit;
    assign gnt_idx[p*IDX_W +: IDX_W] = idx;

    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv));
  end
endmodule

// File: rtl/vq_sched.sv
module vq_sched
  import vq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOW_N = 2,
  parameter int NBC    = 4,
  localparam int NPIPE = 1 << PIPE_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [TAG_W-1:0]       disp_dst,
  input  logic [PIPE_W-1:0]      disp_pipe,
  input  logic [NSRC*TAG_W-1:0]  disp_src_tag,
  input  logic [NSRC*LAT_W-1:0]  disp_src_lat,
  input  logic [NSRC-1:0]        disp_src_rdy,
  input  logic [NBC-1:0]         bc_valid,
  input  logic [NBC*TAG_W-1:0]   bc_tag,
  output logic [NPIPE-1:0]       iss_valid,
  output logic [NPIPE*TAG_W-1:0] iss_dst
);
  ent_t             q  [DEPTH];
  ent_t             nq [DEPTH];
  logic [CNT_W-1:0] occ, occ_n;
  logic             full;
  src_t             wk [DEPTH][NSRC];
  src_t             dcur [NSRC];
  src_t             dnxt [NSRC];
  logic [DEPTH-1:0] elig, issued;
  logic [DEPTH*PIPE_W-1:0] pipe_of;
  logic [NPIPE*IDX_W-1:0]  gnt_idx;

  assign full       = (occ == CNT_W'(DEPTH));
  assign disp_ready = ~full;

  // wakeup of stored sources; slow only in the oldest positions of a full queue
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      vq_src_wake #(.NBC(NBC)) u_wake (
        .cur(q[i].src[s]), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .slow(full && (i < SLOW_N)), .nxt(wk[i][s]));
    end
    always_comb begin
      elig[i] = q[i].vld;
      for (int s = 0; s < NSRC; s++) elig[i] &= src_live(q[i].src[s]);
    end
    assign pipe_of[i*PIPE_W +: PIPE_W] = q[i].pipe;
  end

  // wakeup of the sources arriving with the dispatched micro-op
  for (genvar s = 0; s < NSRC; s++) begin : g_dsrc
    always_comb begin
      dcur[s]       = '0;
      dcur[s].rdy   = disp_src_rdy[s];
      dcur[s].lat   = disp_src_lat[s*LAT_W +: LAT_W];
      dcur[s].tag   = disp_src_tag[s*TAG_W +: TAG_W];
    end
    vq_src_wake #(.NBC(NBC)) u_dwake (
      .cur(dcur[s]), .bc_valid(bc_valid), .bc_tag(bc_tag),
      .slow(1'b0), .nxt(dnxt[s]));
  end

  vq_pick #(.DEPTH(DEPTH), .NPIPE(NPIPE)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .pipe_of(pipe_of),
    .gnt_vld(iss_valid), .gnt_idx(gnt_idx));

  always_comb begin
    issued = '0;
    for (int p = 0; p < NPIPE; p++) begin
      iss_dst[p*TAG_W +: TAG_W] = q[gnt_idx[p*IDX_W +: IDX_W]].dst;
      if (iss_valid[p]) issued[gnt_idx[p*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  // compaction toward the old end, then append at the young end
  always_comb begin
    logic [CNT_W-1:0] k;
    k = '0;
    for (int i = 0; i < DEPTH; i++) nq[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q[i].vld && !issued[i]) begin
        nq[k[IDX_W-1:0]].vld  = 1'b1;
        nq[k[IDX_W-1:0]].pipe = q[i].pipe;
        nq[k[IDX_W-1:0]].dst  = q[i].dst;
        for (int s = 0; s < NSRC; s++) nq[k[IDX_W-1:0]].src[s] = wk[i][s];
        k = k + CNT_W'(1);
      end
    end
    if (disp_valid && disp_ready) begin
      nq[k[IDX_W-1:0]].vld  = 1'b1;
      nq[k[IDX_W-1:0]].pipe = disp_pipe;
      nq[k[IDX_W-1:0]].dst  = disp_dst;
      for (int s = 0; s < NSRC; s++) nq[k[IDX_W-1:0]].src[s] = dnxt[s];
      k = k + CNT_W'(1);
    end
    occ_n = k;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      occ <= occ_n;
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (occ <= $past(occ)));
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  // R7
  grant_vs_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= int'(occ));
endmodule

// File: tb/vq_sched_tb_top.sv
`timescale 1ns/1ps
module vq_sched_tb_top;
  import vq_pkg::*;
  localparam int DEPTH = 8, SLOW_N = 2, NBC = 4, NPIPE = 1 << PIPE_W;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_ready;
  logic [TAG_W-1:0] disp_dst = 0;
  logic [PIPE_W-1:0] disp_pipe = 0;
  logic [NSRC*TAG_W-1:0] disp_src_tag = 0;
  logic [NSRC*LAT_W-1:0] disp_src_lat = 0;
  logic [NSRC-1:0] disp_src_rdy = 0;
  logic [NBC-1:0] bc_valid = 0;
  logic [NBC*TAG_W-1:0] bc_tag = 0;
  logic [NPIPE-1:0] iss_valid;
  logic [NPIPE*TAG_W-1:0] iss_dst;

  vq_sched #(.DEPTH(DEPTH), .SLOW_N(SLOW_N), .NBC(NBC)) dut_i (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  string cur_req = "R7";
  int m_n = 0;
  int m_dst[DEPTH], m_pipe[DEPTH];
  bit m_rdy[DEPTH][NSRC], m_arm[DEPTH][NSRC];
  int m_rc[DEPTH][NSRC], m_lat[DEPTH][NSRC], m_tag[DEPTH][NSRC];

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit bc_hit(int tag);
    for (int b = 0; b < NBC; b++)
      if (bc_valid[b] && int'(bc_tag[b*TAG_W +: TAG_W]) == tag) return 1;
    return 0;
  endfunction

  function automatic bit ent_ok(int i);
    for (int s = 0; s < NSRC; s++)
      if (!(m_rdy[i][s] || (m_arm[i][s] && cyc >= m_rc[i][s]))) return 0;
    return 1;
  endfunction

  function automatic int dst_of(int p);
    return int'(iss_dst[p*TAG_W +: TAG_W]);
  endfunction

  // check this cycle against the model, then advance the model
  task automatic model_step();
    bit iss[DEPTH];
    bit full;
    int k;
    for (int i = 0; i < DEPTH; i++) iss[i] = 0;
    chk(cur_req, int'(disp_ready), int'(m_n < DEPTH));
    for (int p = 0; p < NPIPE; p++) begin
      int ex = -1;
      for (int i = m_n - 1; i >= 0; i--)
        if (m_pipe[i] == p && ent_ok(i)) ex = i;
      chk(cur_req, int'(iss_valid[p]), int'(ex >= 0));
      if (ex >= 0) begin
        if (iss_valid[p]) chk(cur_req, dst_of(p), m_dst[ex]);
        iss[ex] = 1;
      end
    end
    full = (m_n == DEPTH);
    k = 0;
    for (int i = 0; i < m_n; i++) begin
      if (!iss[i]) begin
        for (int s = 0; s < NSRC; s++) begin
          if (!m_rdy[i][s] && !m_arm[i][s] && bc_hit(m_tag[i][s])) begin
            m_arm[i][s] = 1;
            m_rc[i][s] = cyc + m_lat[i][s] + ((full && i < SLOW_N && m_lat[i][s] == 1) ? 1 : 0);
          end
          m_rdy[k][s] = m_rdy[i][s]; m_arm[k][s] = m_arm[i][s];
          m_rc[k][s] = m_rc[i][s]; m_lat[k][s] = m_lat[i][s]; m_tag[k][s] = m_tag[i][s];
        end
        m_dst[k] = m_dst[i]; m_pipe[k] = m_pipe[i];
        k++;
      end
    end
    if (disp_valid && m_n < DEPTH) begin
      m_dst[k] = int'(disp_dst); m_pipe[k] = int'(disp_pipe);
      for (int s = 0; s < NSRC; s++) begin
        m_rdy[k][s] = disp_src_rdy[s];
        m_lat[k][s] = int'(disp_src_lat[s*LAT_W +: LAT_W]);
        m_tag[k][s] = int'(disp_src_tag[s*TAG_W +: TAG_W]);
        m_arm[k][s] = 0; m_rc[k][s] = 0;
        if (!m_rdy[k][s] && bc_hit(m_tag[k][s])) begin
          m_arm[k][s] = 1; m_rc[k][s] = cyc + m_lat[k][s];
        end
      end
      k++;
    end
    m_n = k;
  endtask

  task automatic tick();
    #1;
    model_step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    disp_valid = 0;
    bc_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; disp_valid = 0; bc_valid = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1; m_n = 0;
  endtask

  task automatic disp(int dst, int pipe, int tag0, int lat0, bit rdy0);
    disp_valid = 1; disp_dst = TAG_W'(dst); disp_pipe = PIPE_W'(pipe);
    disp_src_tag = {TAG_W'(0), TAG_W'(tag0)};
    disp_src_lat = {LAT_W'(1), LAT_W'(lat0)};
    disp_src_rdy = {1'b1, rdy0};
  endtask

  task automatic bcast(int tag);
    bc_valid[0] = 1; bc_tag[TAG_W-1:0] = TAG_W'(tag);
  endtask

  task automatic fill(int n, int dst0, int tag, int lat);
    for (int k = 0; k < n; k++) begin disp(dst0 + k, 0, tag, lat, 0); tick(); end
  endtask

  initial begin
    #(200000 * 5);
    nerr++; nchk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'h5eed_0042));
    do_reset();
    #1;
    chk("R1", int'(disp_ready), 1);
    chk("R1", int'(iss_valid), 0);

    // R4: full queue, one-cycle producer, oldest two held back one cycle
    cur_req = "R4";
    fill(DEPTH, 10, 5, 1);
    #1 chk("R2", int'(disp_ready), 0);
    bcast(5); tick();
    #1 chk("R4", int'(iss_valid[0]), 1);
    chk("R4", dst_of(0), 12);
    tick();
    #1 chk("R4", dst_of(0), 10);
    tick();
    #1 chk("R4", dst_of(0), 11);
    repeat (8) tick();

    // R5: full queue, latency 3, no extra cycle in the slow region
    do_reset(); cur_req = "R5";
    fill(DEPTH, 20, 6, 3);
    bcast(6); tick();
    #1 chk("R5", int'(iss_valid[0]), 0);
    tick();
    #1 chk("R5", int'(iss_valid[0]), 0);
    tick();
    #1 chk("R5", dst_of(0), 20);
    repeat (10) tick();

    // R6: one free slot, one-cycle producer, oldest issues at T+1
    do_reset(); cur_req = "R6";
    fill(DEPTH - 1, 30, 7, 1);
    bcast(7); tick();
    #1 chk("R6", int'(iss_valid[0]), 1);
    chk("R6", dst_of(0), 30);
    repeat (8) tick();

    // R2: request while full is ignored
    do_reset(); cur_req = "R2";
    fill(DEPTH, 0, 9, 2);
    disp(63, 3, 0, 1, 1); tick();
    #1 chk("R2", int'(disp_ready), 0);
    chk("R2", int'(iss_valid[3]), 0);
    bcast(9); tick();
    seen = 0;
    for (int k = 0; k < 12; k++) begin #1 if (iss_valid[3]) seen = 1; tick(); end
    chk("R2", int'(seen), 0);

    // R8 and R7: issue during dispatch, broadcast in dispatch cycle, four grants
    do_reset(); cur_req = "R8";
    disp(40, 0, 0, 1, 1); tick();
    disp(41, 1, 0, 1, 1);
    #1 chk("R8", int'(iss_valid[0]), 1);
    chk("R8", dst_of(0), 40);
    tick();
    disp(42, 2, 12, 1, 0); bcast(12); tick();
    #1 chk("R8", int'(iss_valid[2]), 1);
    chk("R8", dst_of(2), 42);
    tick(); tick();
    cur_req = "R7";
    for (int k = 0; k < 4; k++) begin disp(50 + k, 3 - k, 11, 2, 0); tick(); end
    disp(54, 0, 11, 2, 0); tick();
    bcast(11); tick();
    #1 chk("R3", int'(iss_valid), 0);
    tick();
    #1 chk("R7", int'(iss_valid), 15);
    chk("R7", dst_of(0), 53);
    chk("R7", dst_of(3), 50);
    tick();
    #1 chk("R7", dst_of(0), 54);
    tick();

    // R3: source ready at dispatch issues next cycle
    cur_req = "R3";
    disp(33, 1, 0, 1, 1); tick();
    #1 chk("R3", dst_of(1), 33);
    tick();

    // random traffic: model checks every cycle
    do_reset(); cur_req = "R7";
    for (int c = 0; c < 4000; c++) begin
      bit heavy = ((c / 500) % 2) == 0;
      if ($urandom_range(0, 9) < (heavy ? 9 : 4)) begin
        disp_valid = 1;
        disp_dst = TAG_W'($urandom);
        disp_pipe = PIPE_W'($urandom);
        for (int s = 0; s < NSRC; s++) begin
          disp_src_tag[s*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 15));
          disp_src_lat[s*LAT_W +: LAT_W] =
            LAT_W'(($urandom_range(0, 2) == 0) ? $urandom_range(2, 5) : 1);
          disp_src_rdy[s] = ($urandom_range(0, 3) == 0);
        end
      end
      for (int b = 0; b < NBC; b++) begin
        bc_valid[b] = ($urandom_range(0, 9) < (heavy ? 2 : 4));
        bc_tag[b*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 15));
      end
      tick();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule